// File: doc/BRIEF.md
# Extended-Precision Shift and Field Unit

This block is the bit-manipulation stage of a DSP datapath. It works on 40-bit words, the width of an accumulator. One operation code selects what it does to the operand. It can shift or rotate the operand by a signed amount. It can count the operand's redundant sign bits, so that software knows how far to shift left to left-justify the value. It can also pull a bit field out of the operand, or write a bit field into it.

The datapath is combinational. Its output is captured in one register stage when `start_i` is high. The result appears with `valid_o` on the following cycle. Zero and negative flags are registered at the same time as the result and describe the result currently held.

Top module: `shift_field_unit`

## Requirements
- R1: After reset, and before any start, `valid_o` is 0, `result_o` is 0, `zero_o` is 1 and `neg_o` is 0.
- R2: A start in one cycle raises `valid_o` in the next cycle, with the result of the inputs sampled at that start. In a cycle with no start, `valid_o` is 0 in the next cycle and `result_o` and the flags keep their values.
- R3: Op code 0 is the logical shift. A positive amount shifts left and a negative amount shifts right. Vacated bits are filled with zeros, and a magnitude of 40 or more gives all zeros.
- R4: Op code 1 is the arithmetic shift. A positive amount shifts left, exactly like op 0. A negative amount shifts right and fills with bit 39. A right magnitude of 40 or more gives 40 copies of bit 39.
- R5: Op code 2 rotates through 40 bits. A positive amount rotates left and a negative amount rotates right, both taken modulo 40.
- R6: Op code 3 returns, zero-extended, the count of consecutive bits from bit 38 downward that equal bit 39. An all-zero or all-ones operand gives 39.
- R7: Op code 4 with `sext_i`=0 returns bits [pos+len-1:pos] of the operand in the low `len` bits, with zeros above them. Operand bits above 39 read as zero, a length of 0 gives 0, and a length of 40 or more takes all remaining bits.
- R8: Op code 4 with `sext_i`=1 behaves like R7, but every bit at or above `len` copies extracted bit len-1. Lengths of 0 or 40 and more are not extended.
- R9: Op code 5 replaces operand bits [pos+len-1:pos] with the low `len` bits of `insert_i`. Bits outside the field are unchanged, and field bits above 39 are dropped.
- R10: `zero_o` is 1 exactly when the registered result is 0. `neg_o` equals bit 39 of the registered result.
- R11: Op codes 6 and 7 are reserved and produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the result of the current inputs |
| op_i | input | 3 | Operation code |
| operand_i | input | 40 | Source word |
| insert_i | input | 40 | Field source for deposit |
| amount_i | input | 8 | Signed shift or rotate amount, two's complement |
| pos_i | input | 6 | Field position (lowest bit) |
| len_i | input | 6 | Field length in bits |
| sext_i | input | 1 | Sign-extend the extracted field |
| valid_o | output | 1 | Result registered from the previous cycle's start |
| result_o | output | 40 | Registered result |
| zero_o | output | 1 | Registered result is zero |
| neg_o | output | 1 | Bit 39 of the registered result |

## Verification
The hardest cases to reach are the places where the field and shift arithmetic reach past the word. These are a field that runs off the top of bit 39, a length larger than the word, a length of zero, and shift amounts at or beyond 40 in either direction, including -128. Rotations whose amount is a multiple of 40, or wraps past it, are also hard to reach. Directed operations aim at each of these edges. A run of pseudo-random operations over the full 6-bit position and length range, and the full 8-bit amount range, follows them. Every result is compared in order against a bit-by-bit reference model in a queue.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [2:0] {
    OP_LSH  = 3'd0,
    OP_ASH  = 3'd1,
    OP_ROT  = 3'd2,
    OP_NORM = 3'd3,
    OP_EXTR = 3'd4,
    OP_DEP  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } sfu_op_e;
endpackage

// File: rtl/sfu_shifter.sv
module sfu_shifter #(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned AMT_W = 8
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             arith_i,
  input  logic             rotate_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int unsigned MAG_W = AMT_W + 1;
  localparam logic [MAG_W-1:0] W_M = MAG_W'(WIDTH);

  logic                   dir_right;
  logic [MAG_W-1:0]       mag;
  logic [MAG_W-1:0]       rem;
  logic [MAG_W-1:0]       rot_left;
  logic [WIDTH-1:0]       left_res;
  logic [WIDTH-1:0]       right_res;
  logic [WIDTH-1:0]       fill;
  logic [2*WIDTH-1:0]     dbl;

  assign dir_right = amount_i[AMT_W-1];
  // magnitude needs one extra bit for the most negative amount
  assign mag  = dir_right ? (MAG_W'(0) - {amount_i[AMT_W-1], amount_i})
                          : {1'b0, amount_i};
  assign fill = {WIDTH{arith_i & operand_i[WIDTH-1]}};

  always_comb begin
    left_res  = (mag >= W_M) ? '0 : (operand_i << mag);
    if (mag >= W_M)
      right_res = fill;
    else if (arith_i)
      right_res = WIDTH'($signed(operand_i) >>> mag);
    else
      right_res = operand_i >> mag;
  end

  // rotate right by k == rotate left by WIDTH-k
  assign rem      = mag % W_M;
  assign rot_left = (dir_right && rem != '0) ? (W_M - rem) : rem;
  assign dbl      = {operand_i, operand_i} << rot_left;

  always_comb begin
    if (rotate_i)       res_o = dbl[2*WIDTH-1:WIDTH];
    else if (dir_right) res_o = right_res;
    else                res_o = left_res;
  end

  always_comb begin
    if (rotate_i) begin
      AST_ROT_BITS_KEPT: assert ($countones(res_o) == $countones(operand_i)) else $error("rotate lost bits"); // R5
    end
    if (arith_i && !rotate_i && dir_right) begin
      AST_ASR_SIGN_KEPT: assert (res_o[WIDTH-1] == operand_i[WIDTH-1]) else $error("sign not kept"); // R4
    end
  end
endmodule

// File: rtl/sfu_norm.sv
module sfu_norm #(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned CNT_W = 6
) (
  input  logic [WIDTH-1:0] operand_i,
  output logic [CNT_W-1:0] count_o
);
  logic run;

  always_comb begin
    count_o = '0;
    run     = 1'b1;
    for (int i = WIDTH - 2; i >= 0; i--) begin
      if (run && (operand_i[i] == operand_i[WIDTH-1])) count_o = count_o + 1'b1;
      else run = 1'b0;
    end
  end

  logic [WIDTH-1:0] justified;
  assign justified = operand_i << count_o;

  always_comb begin
    AST_NORM_SIGN_HELD: assert (justified[WIDTH-1] == operand_i[WIDTH-1]) else $error("norm overshoot"); // R6
    if (count_o < CNT_W'(WIDTH - 1)) begin
      AST_NORM_JUSTIFIED: assert (justified[WIDTH-2] != operand_i[WIDTH-1]) else $error("norm short"); // R6
    end
  end
endmodule

// File: rtl/sfu_field.sv
module sfu_field #(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned POS_W = 6,
  parameter int unsigned LEN_W = 6
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [WIDTH-1:0] insert_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             sext_i,
  output logic [WIDTH-1:0] extr_o,
  output logic [WIDTH-1:0] dep_o
);
  logic [WIDTH-1:0] low_mask;
  logic [WIDTH-1:0] dep_mask;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] field;
  logic             top_bit;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_mask
    assign low_mask[gi] = (32'(len_i) > gi);
  end

  assign dep_mask = low_mask << pos_i;
  assign shifted  = operand_i >> pos_i;
  assign field    = shifted & low_mask;
  // bit len-1 picked by the mask edge; zero when len is 0 or covers the word
  assign top_bit  = |(shifted & low_mask & ~(low_mask >> 1)) & ~low_mask[WIDTH-1];
  assign extr_o   = field | ((sext_i && top_bit) ? ~low_mask : '0);
  assign dep_o    = (operand_i & ~dep_mask) | ((insert_i << pos_i) & dep_mask);

  always_comb begin
    AST_DEP_OUTSIDE_KEPT: assert (((dep_o ^ operand_i) & ~dep_mask) == '0) else $error("deposit spill"); // R9
    if (!sext_i) begin
      AST_EXTR_ZERO_HIGH: assert ((extr_o & ~low_mask) == '0) else $error("extract high bits"); // R7
    end
  end
endmodule

// File: rtl/shift_field_unit.sv
module shift_field_unit
  import sfu_pkg::*;
#(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned AMT_W = 8,
  parameter int unsigned POS_W = 6,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [WIDTH-1:0] insert_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             sext_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             neg_o
);
  localparam int unsigned CNT_W = $clog2(WIDTH);

  sfu_op_e          op;
  logic [WIDTH-1:0] shift_res;
  logic [CNT_W-1:0] norm_cnt;
  logic [WIDTH-1:0] extr_res;
  logic [WIDTH-1:0] dep_res;
  logic [WIDTH-1:0] res_d;

  assign op = sfu_op_e'(op_i);

  sfu_shifter #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_shifter (
    .operand_i (operand_i),
    .amount_i  (amount_i),
    .arith_i   (op == OP_ASH),
    .rotate_i  (op == OP_ROT),
    .res_o     (shift_res)
  );

  sfu_norm #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_norm (
    .operand_i (operand_i),
    .count_o   (norm_cnt)
  );

  sfu_field #(.WIDTH(WIDTH), .POS_W(POS_W), .LEN_W(LEN_W)) i_field (
    .operand_i (operand_i),
    .insert_i  (insert_i),
    .pos_i     (pos_i),
    .len_i     (len_i),
    .sext_i    (sext_i),
    .extr_o    (extr_res),
    .dep_o     (dep_res)
  );

  always_comb begin
    unique case (op)
      OP_LSH, OP_ASH, OP_ROT: res_d = shift_res;
      OP_NORM:                res_d = {{(WIDTH-CNT_W){1'b0}}, norm_cnt};
      OP_EXTR:                res_d = extr_res;
      OP_DEP:                 res_d = dep_res;
      default:                res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      zero_o   <= 1'b1;
      neg_o    <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        result_o <= res_d;
        zero_o   <= ~|res_d;
        neg_o    <= res_d[WIDTH-1];
      end
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o) else $error("valid missing"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!valid_o && $stable(result_o))) else $error("idle changed result"); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o == (result_o == '0)) else $error("zero flag"); // R10
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_o == result_o[WIDTH-1]) else $error("neg flag"); // R10
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i[2:1] == 2'b11) |=> result_o == '0) else $error("reserved op"); // R11
endmodule

// File: tb/test_shift_field_unit.sv
module test_shift_field_unit;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [39:0] operand_i = '0;
  logic [39:0] insert_i = '0;
  logic [7:0]  amount_i = '0;
  logic [5:0]  pos_i = '0;
  logic [5:0]  len_i = '0;
  logic        sext_i = 1'b0;
  logic        valid_o;
  logic [39:0] result_o;
  logic        zero_o;
  logic        neg_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [39:0] res;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_P/2) clk_i = ~clk_i;

  shift_field_unit i_shift_field_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .operand_i(operand_i), .insert_i(insert_i), .amount_i(amount_i),
    .pos_i(pos_i), .len_i(len_i), .sext_i(sext_i),
    .valid_o(valid_o), .result_o(result_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  function automatic logic [39:0] model(int op, logic [39:0] x, logic [39:0] ins,
                                        int amt, int pos, int len, bit sx);
    logic [39:0] r = '0;
    int src, n;
    case (op)
      0, 1: for (int i = 0; i < 40; i++) begin
        src = i - amt;
        if (src >= 0 && src < 40) r[i] = x[src];
        else if (src >= 40 && op == 1) r[i] = x[39];
        else r[i] = 1'b0;
      end
      2: for (int i = 0; i < 40; i++) begin
        src = ((i - amt) % 40 + 40) % 40;
        r[i] = x[src];
      end
      3: begin
        n = 0;
        for (int i = 38; i >= 0; i--) begin
          if (x[i] != x[39]) break;
          n++;
        end
        r = 40'(n);
      end
      4: begin
        for (int i = 0; i < 40; i++)
          if (i < len) r[i] = (pos + i < 40) ? x[pos + i] : 1'b0;
        if (sx && len > 0 && len < 40)
          for (int i = len; i < 40; i++) r[i] = r[len - 1];
      end
      5: begin
        r = x;
        for (int i = 0; i < len && i < 40; i++)
          if (pos + i < 40) r[pos + i] = ins[i];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic drive(int op, logic [39:0] x, logic [39:0] ins, int amt,
                       int pos, int len, bit sx, string tag);
    exp_t e;
    @(negedge clk_i);
    start_i   = 1'b1;
    op_i      = 3'(op);
    operand_i = x;
    insert_i  = ins;
    amount_i  = 8'(amt);
    pos_i     = 6'(pos);
    len_i     = 6'(len);
    sext_i    = sx;
    e.res = model(op, x, ins, amt, pos, len, sx);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      exp_t e;
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: valid without start, got %h expected no result", result_o);
      end else begin
        e = sb_q.pop_front();
        if (result_o !== e.res) begin
          n_fail++;
          $display("FAIL %s: result %h expected %h", e.tag, result_o, e.res);
        end
        n_tests++;
        if (zero_o !== (e.res == '0) || neg_o !== e.res[39]) begin
          n_fail++;
          $display("FAIL R10: flags z=%b n=%b expected z=%b n=%b",
                   zero_o, neg_o, (e.res == '0), e.res[39]);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  localparam logic [39:0] A = 40'h9A_5C3E_71B4;
  localparam logic [39:0] B = 40'h3F_00F0_0A5D;
  localparam logic [39:0] INS = 40'h12_3456_789B;

  initial begin
    logic [39:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    n_tests++;
    if (valid_o !== 1'b0 || result_o !== '0 || zero_o !== 1'b1 || neg_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: v=%b r=%h z=%b n=%b expected 0 0 1 0", valid_o, result_o, zero_o, neg_o);
    end

    // R3 logical shifts
    drive(0, A, '0, 4, 0, 0, 0, "R3");
    drive(0, A, '0, -4, 0, 0, 0, "R3");
    drive(0, A, '0, 39, 0, 0, 0, "R3");
    drive(0, A, '0, 40, 0, 0, 0, "R3");
    drive(0, A, '0, -45, 0, 0, 0, "R3");
    drive(0, A, '0, 0, 0, 0, 0, "R3");
    // R4 arithmetic shifts
    drive(1, A, '0, -1, 0, 0, 0, "R4");
    drive(1, A, '0, -39, 0, 0, 0, "R4");
    drive(1, A, '0, -60, 0, 0, 0, "R4");
    drive(1, A, '0, -128, 0, 0, 0, "R4");
    drive(1, B, '0, -7, 0, 0, 0, "R4");
    drive(1, B, '0, 3, 0, 0, 0, "R4");
    // R5 rotates
    drive(2, A, '0, 5, 0, 0, 0, "R5");
    drive(2, A, '0, -5, 0, 0, 0, "R5");
    drive(2, A, '0, 40, 0, 0, 0, "R5");
    drive(2, A, '0, 85, 0, 0, 0, "R5");
    drive(2, A, '0, -128, 0, 0, 0, "R5");
    drive(2, B, '0, -80, 0, 0, 0, "R5");
    // R6 normalization
    drive(3, '0, '0, 0, 0, 0, 0, "R6");
    drive(3, '1, '0, 0, 0, 0, 0, "R6");
    drive(3, 40'h1, '0, 0, 0, 0, 0, "R6");
    drive(3, 40'h7F_FFFF_FFFF, '0, 0, 0, 0, 0, "R6");
    drive(3, 40'hC0_0000_0000, '0, 0, 0, 0, 0, "R6");
    drive(3, 40'hFF_FFFF_F800, '0, 0, 0, 0, 0, "R6");
    // R7 zero-extended extract
    drive(4, A, '0, 0, 8, 12, 0, "R7");
    drive(4, A, '0, 0, 36, 10, 0, "R7");
    drive(4, A, '0, 0, 5, 0, 0, "R7");
    drive(4, A, '0, 0, 0, 63, 0, "R7");
    drive(4, A, '0, 0, 50, 8, 0, "R7");
    // R8 sign-extended extract
    drive(4, A, '0, 0, 4, 8, 1, "R8");
    drive(4, A, '0, 0, 36, 4, 1, "R8");
    drive(4, A, '0, 0, 3, 1, 1, "R8");
    drive(4, A, '0, 0, 0, 40, 1, "R8");
    drive(4, A, '0, 0, 7, 0, 1, "R8");
    // R9 deposit
    drive(5, A, INS, 0, 4, 8, 0, "R9");
    drive(5, A, INS, 0, 35, 10, 0, "R9");
    drive(5, A, INS, 0, 10, 0, 0, "R9");
    drive(5, A, INS, 0, 0, 63, 0, "R9");
    // R10 flags on zero and negative results
    drive(0, 40'h80_0000_0000, '0, 0, 0, 0, 0, "R10");
    drive(0, 40'h1, '0, -1, 0, 0, 0, "R10");
    // R11 reserved codes
    drive(6, A, INS, 3, 2, 5, 1, "R11");
    drive(7, '1, INS, -3, 2, 5, 1, "R11");

    for (int k = 0; k < 200; k++) begin
      int op;
      string tg;
      op = int'($urandom % 8);
      case (op)
        0: tg = "R3"; 1: tg = "R4"; 2: tg = "R5"; 3: tg = "R6";
        4: tg = "R7"; 5: tg = "R9"; default: tg = "R11";
      endcase
      drive(op, {8'($urandom), 32'($urandom)}, {8'($urandom), 32'($urandom)},
            int'($urandom % 256) - 128, int'($urandom % 64), int'($urandom % 64),
            bit'($urandom % 2), tg);
    end

    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R2: idle cycles leave the result and flags untouched
    held = result_o;
    op_i = 3'd3; operand_i = '0; start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    n_tests++;
    if (valid_o !== 1'b0 || result_o !== held) begin
      n_fail++;
      $display("FAIL R2: v=%b r=%h expected v=0 r=%h", valid_o, result_o, held);
    end
    n_tests++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule